// File: doc/BRIEF.md
# Serial Command Front End for a Dual Wiper Register Pair

This block is the digital control front end of a two-channel position register device. A host talks to it over a three-wire serial slave link: an active-low select, a serial clock, and a data input that is sampled on each rising serial clock edge, most significant bit first. A command frame is 24 bits long. The block shifts the frame in, and acts on it only when the select line returns high. It then updates the two 10-bit wiper positions, asks the nonvolatile sequencer to store a position, or prepares a readback word.

The serial data output supports daisy-chaining. While a frame shifts in, the output presents the bits of the previous frame, each one 24 serial clocks late. After a read command, the output presents the 24-bit readback word instead of the old frame. An active-low write-protect input stops serial commands from changing the wipers. A hardware preset input still reloads both wipers from the stored values when it is released.

The serial pins are asynchronous to the system clock. All of them are synchronised and edge-detected inside the block, so the serial clock must be several times slower than the system clock.

Top module: `dual_wiper_serial_ctrl`

## Requirements
- R1: While `rst` is high and just after it falls, both wipers hold position 512, `ser_sdo` is 1 and `store_req` is 0.
- R2: Command code 11 in frame bits 23:20 writes frame bits 9:0 to the wiper selected by frame bits 19:16. Address 0 selects channel 0 (`wiper_pos[9:0]`) and address 1 selects channel 1 (`wiper_pos[19:10]`). The write takes effect after `ser_csn` rises.
- R3: A frame that is not exactly 24 serial clocks long is ignored. No wiper changes, no store request is raised and no readback word is loaded.
- R4: A frame whose address field holds a value other than 0 or 1 leaves both wipers unchanged.
- R5: `ser_sdo` is 1 whenever the select line is high.
- R6: During a frame, the bit on `ser_sdo` before serial clock rise k equals the bit shifted in 24 rises earlier. After a 24-bit non-read frame, this means the previous frame is replayed MSB first.
- R7: After command 10, the next frame's `ser_sdo` carries a 24-bit word: 14 zero bits, then the addressed wiper value. After command 9, it carries the addressed stored value from `nv_val` in the same layout. An invalid address gives all zeros.
- R8: While `wp_n` is low, commands 11, 1 and 8 do not change any wiper.
- R9: Command 1 reloads the addressed wiper from its stored value in `nv_val`. Command 8 reloads both wipers. No other event changes a wiper.
- R10: A rising edge on `preset_n` reloads both wipers from `nv_val`, even while `wp_n` is low.
- R11: Command 2 with address 0 or 1 raises `store_req` for exactly one cycle. `store_addr` carries the address and `store_data` carries that wiper's value. With any other address, no request is raised.
- R12: Command 0 and unassigned command codes change no wiper and raise no store request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_csn | input | 1 | Active-low frame select; a rising edge ends the frame |
| ser_sdi | input | 1 | Serial data in, MSB first |
| ser_sdo | output | 1 | Serial data out: echo or readback; 1 when idle |
| wp_n | input | 1 | Active-low write protect for wiper-changing commands |
| preset_n | input | 1 | Active-low preset; a rising edge reloads both wipers |
| nv_val | input | CH*WW | Stored positions from the nonvolatile sequencer, channel 0 in the low bits |
| store_req | output | 1 | One-cycle request to store a position |
| store_addr | output | 4 | Channel to store |
| store_data | output | WW | Position to store |
| wiper_pos | output | CH*WW | Current wiper positions, channel 0 in the low bits |

## Verification
A fault in the bit counter or the frame-end detector shows up at the end of that same frame. A bad-length frame would then move a wiper, or a good frame would fail to move one, within a few system cycles of the select line rising. A fault in the shift register shows up on `ser_sdo` during the very next frame, because every echoed or readback bit is compared as it appears. Write-protect and preset faults appear as a wrong wiper value about a dozen cycles after the frame or pulse. The bench compares the wipers against its behavioural model on every settled clock.

// File: rtl/dw_pkg.sv
package dw_pkg;
  localparam int FRAME_W  = 24;
  localparam int OP_W     = 4;
  localparam int ADDR_W   = 4;
  localparam int OP_MSB   = FRAME_W - 1;
  localparam int OP_LSB   = FRAME_W - OP_W;
  localparam int ADDR_MSB = OP_LSB - 1;
  localparam int ADDR_LSB = OP_LSB - ADDR_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP        = 4'd0,
    OP_RELOAD     = 4'd1,
    OP_STORE      = 4'd2,
    OP_RELOAD_ALL = 4'd8,
    OP_RD_NV      = 4'd9,
    OP_RD_WIPER   = 4'd10,
    OP_WRITE      = 4'd11
  } op_e;
endpackage

// File: rtl/dw_sync.sv
module dw_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[0] <= RST_VAL;
        else     stage[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= RST_VAL;
        else     stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dw_shifter.sv
module dw_shifter #(
  parameter int FRAME_W = 24,
  parameter int CNT_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_rise,
  input  logic               csn_s,
  input  logic               csn_fall,
  input  logic               sdi_s,
  input  logic               load_en,
  input  logic [FRAME_W-1:0] load_word,
  output logic [FRAME_W-1:0] shreg,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic               sdo
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);

  logic shift_en;
  assign shift_en = !csn_s && sclk_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (load_en) begin
      shreg <= load_word;
    end else if (shift_en) begin
      shreg <= {shreg[FRAME_W-2:0], sdi_s};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
    end else if (csn_fall) begin
      bit_cnt <= '0;
    end else if (shift_en && bit_cnt != CNT_MAX) begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sdo <= 1'b1;
    else     sdo <= csn_s ? 1'b1 : shreg[FRAME_W-1];
  end
endmodule

// File: rtl/dw_decode.sv
module dw_decode
  import dw_pkg::*;
#(
  parameter int CH = 2,
  parameter int WW = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go,
  input  logic [FRAME_W-1:0]      frame,
  input  logic                    wp_ok,
  input  logic [CH-1:0][WW-1:0]   wiper_now,
  input  logic [CH-1:0][WW-1:0]   nv_now,
  output logic [CH-1:0]           wr_mask,
  output logic [CH-1:0][WW-1:0]   wr_val,
  output logic                    rd_load,
  output logic [FRAME_W-1:0]      rd_word,
  output logic                    store_req,
  output logic [ADDR_W-1:0]       store_addr,
  output logic [WW-1:0]           store_data
);
  op_e               op;
  logic [ADDR_W-1:0] addr;
  logic [WW-1:0]     data;
  logic [CH-1:0]     hit;
  logic              addr_ok;
  logic [WW-1:0]     sel_wiper, sel_nv;
  logic              unused_bits;

  assign op          = op_e'(frame[OP_MSB:OP_LSB]);
  assign addr        = frame[ADDR_MSB:ADDR_LSB];
  assign data        = frame[WW-1:0];
  assign unused_bits = ^frame[ADDR_LSB-1:WW];

  for (genvar g = 0; g < CH; g++) begin : g_hit
    assign hit[g] = (addr == ADDR_W'(g));
  end
  assign addr_ok = |hit;

  always_comb begin
    sel_wiper = '0;
    sel_nv    = '0;
    for (int i = 0; i < CH; i++) begin
      if (hit[i]) begin
        sel_wiper = wiper_now[i];
        sel_nv    = nv_now[i];
      end
    end
  end

  logic [CH-1:0]         n_mask;
  logic [CH-1:0][WW-1:0] n_val;
  logic                  n_rd;
  logic [FRAME_W-1:0]    n_word;
  logic                  n_st;

  always_comb begin
    n_mask = '0;
    n_val  = '0;
    n_rd   = 1'b0;
    n_word = '0;
    n_st   = 1'b0;
    case (op)
      OP_WRITE: begin
        if (wp_ok) n_mask = hit;
        for (int i = 0; i < CH; i++) n_val[i] = data;
      end
      OP_RELOAD: begin
        if (wp_ok) n_mask = hit;
        n_val = nv_now;
      end
      OP_RELOAD_ALL: begin
        if (wp_ok) n_mask = '1;
        n_val = nv_now;
      end
      OP_STORE: n_st = addr_ok;
      OP_RD_NV: begin
        n_rd   = 1'b1;
        n_word = FRAME_W'(sel_nv);
      end
      OP_RD_WIPER: begin
        n_rd   = 1'b1;
        n_word = FRAME_W'(sel_wiper);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_mask    <= '0;
      wr_val     <= '0;
      rd_load    <= 1'b0;
      rd_word    <= '0;
      store_req  <= 1'b0;
      store_addr <= '0;
      store_data <= '0;
    end else if (go) begin
      wr_mask    <= n_mask;
      wr_val     <= n_val;
      rd_load    <= n_rd;
      rd_word    <= n_word;
      store_req  <= n_st;
      store_addr <= addr;
      store_data <= sel_wiper;
    end else begin
      wr_mask   <= '0;
      rd_load   <= 1'b0;
      store_req <= 1'b0;
    end
  end
endmodule

// File: rtl/dw_wiper_bank.sv
module dw_wiper_bank #(
  parameter int CH = 2,
  parameter int WW = 10,
  parameter int RESET_POS = 512
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  preset_ld,
  input  logic [CH-1:0][WW-1:0] nv_now,
  input  logic [CH-1:0]         wr_mask,
  input  logic [CH-1:0][WW-1:0] wr_val,
  output logic [CH-1:0][WW-1:0] wiper
);
  for (genvar g = 0; g < CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)             wiper[g] <= WW'(RESET_POS);
      else if (preset_ld)  wiper[g] <= nv_now[g];
      else if (wr_mask[g]) wiper[g] <= wr_val[g];
    end
  end
endmodule

// File: rtl/dual_wiper_serial_ctrl.sv
module dual_wiper_serial_ctrl
  import dw_pkg::*;
#(
  parameter int CH = 2,
  parameter int WW = 10,
  parameter int SYNC = 2,
  parameter int RESET_POS = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk,
  input  logic               ser_csn,
  input  logic               ser_sdi,
  output logic               ser_sdo,
  input  logic               wp_n,
  input  logic               preset_n,
  input  logic [CH*WW-1:0]   nv_val,
  output logic               store_req,
  output logic [ADDR_W-1:0]  store_addr,
  output logic [WW-1:0]      store_data,
  output logic [CH*WW-1:0]   wiper_pos
);
  localparam int CNT_W = $clog2(FRAME_W + 2);

  logic [4:0] sync_q;
  logic sclk_s, csn_s, sdi_s, wp_s, pr_s;
  logic sclk_d, csn_d, pr_d;
  logic sclk_rise, csn_fall, csn_rise, preset_ld, go;

  dw_sync #(.W(5), .STAGES(SYNC), .RST_VAL(5'b01011)) u_sync (
    .clk(clk), .rst(rst),
    .d({ser_clk, ser_csn, ser_sdi, wp_n, preset_n}),
    .q(sync_q)
  );
  assign {sclk_s, csn_s, sdi_s, wp_s, pr_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
      pr_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
      pr_d   <= pr_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign csn_fall  = csn_d & ~csn_s;
  assign csn_rise  = ~csn_d & csn_s;
  assign preset_ld = pr_s & ~pr_d;

  logic [FRAME_W-1:0]    shreg;
  logic [CNT_W-1:0]      bit_cnt;
  logic [CH-1:0]         wr_mask;
  logic [CH-1:0][WW-1:0] wr_val;
  logic                  rd_load;
  logic [FRAME_W-1:0]    rd_word;
  logic [CH-1:0][WW-1:0] wiper;
  logic [CH-1:0][WW-1:0] nv_arr;

  assign nv_arr = nv_val;
  assign go     = csn_rise && (bit_cnt == CNT_W'(FRAME_W));

  dw_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst),
    .sclk_rise(sclk_rise), .csn_s(csn_s), .csn_fall(csn_fall), .sdi_s(sdi_s),
    .load_en(rd_load), .load_word(rd_word),
    .shreg(shreg), .bit_cnt(bit_cnt), .sdo(ser_sdo)
  );

  dw_decode #(.CH(CH), .WW(WW)) u_dec (
    .clk(clk), .rst(rst), .go(go), .frame(shreg), .wp_ok(wp_s),
    .wiper_now(wiper), .nv_now(nv_arr),
    .wr_mask(wr_mask), .wr_val(wr_val),
    .rd_load(rd_load), .rd_word(rd_word),
    .store_req(store_req), .store_addr(store_addr), .store_data(store_data)
  );

  dw_wiper_bank #(.CH(CH), .WW(WW), .RESET_POS(RESET_POS)) u_bank (
    .clk(clk), .rst(rst), .preset_ld(preset_ld), .nv_now(nv_arr),
    .wr_mask(wr_mask), .wr_val(wr_val), .wiper(wiper)
  );

  assign wiper_pos = wiper;
endmodule

// File: rtl/dw_ctrl_chk.sv
module dw_ctrl_chk #(
  parameter int CH = 2,
  parameter int WW = 10,
  parameter int CNT_W = 5,
  parameter int FRAME_W = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               csn_s,
  input logic               ser_sdo,
  input logic               store_req,
  input logic               rd_load,
  input logic               wp_s,
  input logic               preset_ld,
  input logic [CH-1:0]      wr_mask,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic [CH*WW-1:0]   wiper_pos
);
  // R5: released output while deselected
  assert_sdo_idle_R5: assert property (@(posedge clk) disable iff (rst)
    $past(csn_s) |-> ser_sdo);

  // R11: store request lasts a single cycle
  assert_store_single_R11: assert property (@(posedge clk) disable iff (rst)
    store_req |=> !store_req);

  // R8: no wiper-changing strobe unless protect was released
  assert_wp_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (|wr_mask) |-> $past(wp_s));

  // R3: any action needs a full 24-bit frame
  assert_len_gate_R3: assert property (@(posedge clk) disable iff (rst)
    ((|wr_mask) || rd_load || store_req) |-> ($past(bit_cnt) == CNT_W'(FRAME_W)));

  // R9: wipers move only after a write strobe or a preset
  assert_wiper_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(|wr_mask) && !$past(preset_ld)) |-> $stable(wiper_pos));
endmodule

bind dual_wiper_serial_ctrl dw_ctrl_chk #(
  .CH(CH), .WW(WW), .CNT_W(CNT_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rst(rst), .csn_s(csn_s), .ser_sdo(ser_sdo),
  .store_req(store_req), .rd_load(rd_load), .wp_s(wp_s),
  .preset_ld(preset_ld), .wr_mask(wr_mask), .bit_cnt(bit_cnt),
  .wiper_pos(wiper_pos)
);

// File: tb/dual_wiper_serial_ctrl_test.sv
module dual_wiper_serial_ctrl_test;
  localparam logic [9:0] NV0 = 10'h0AA;
  localparam logic [9:0] NV1 = 10'h2C3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_csn = 1'b1, ser_sdi = 1'b0;
  logic wp_n = 1'b1, preset_n = 1'b1;
  logic [19:0] nv_val;
  logic ser_sdo, store_req;
  logic [3:0] store_addr;
  logic [9:0] store_data;
  logic [19:0] wiper_pos;

  assign nv_val = {NV1, NV0};

  always #5 clk = ~clk;

  dual_wiper_serial_ctrl uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_csn(ser_csn), .ser_sdi(ser_sdi),
    .ser_sdo(ser_sdo), .wp_n(wp_n), .preset_n(preset_n), .nv_val(nv_val),
    .store_req(store_req), .store_addr(store_addr), .store_data(store_data),
    .wiper_pos(wiper_pos)
  );

  int checks = 0;
  int fails = 0;
  logic [9:0] mw [2];
  logic sq [$];
  bit settled = 1'b0;
  int st_seen = 0;
  logic [3:0] st_addr;
  logic [9:0] st_data;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] fr(input int op, input int a, input int d);
    return {op[3:0], a[3:0], d[15:0]};
  endfunction

  task automatic load_q(input logic [23:0] w);
    sq.delete();
    for (int i = 23; i >= 0; i--) sq.push_back(w[i]);
  endtask

  // behavioural reaction to a complete 24-bit frame
  task automatic model_apply(input logic [23:0] w);
    int op = int'(w[23:20]);
    int a = int'(w[19:16]);
    logic [9:0] d = w[9:0];
    case (op)
      11: if (wp_n && a < 2) mw[a] = d;
      1:  if (wp_n && a < 2) mw[a] = (a == 0) ? NV0 : NV1;
      8:  if (wp_n) begin mw[0] = NV0; mw[1] = NV1; end
      9:  load_q(24'((a == 0) ? NV0 : (a == 1) ? NV1 : 10'h0));
      10: load_q(24'((a < 2) ? mw[a] : 10'h0));
      default: ;
    endcase
  endtask

  task automatic send(input logic [23:0] w, input int n);
    ser_csn = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      logic b = (i < 24) ? w[23-i] : 1'b0;
      logic e;
      ser_sdi = b;
      ser_clk = 1'b0;
      repeat (6) @(negedge clk);
      e = sq.pop_front();
      chk(ser_sdo === e, "R6/R7 sdo bit", 32'(ser_sdo), 32'(e));
      sq.push_back(b);
      ser_clk = 1'b1;
      repeat (6) @(negedge clk);
    end
    ser_clk = 1'b0;
    repeat (6) @(negedge clk);
    settled = 1'b0;
    ser_csn = 1'b1;
    if (n == 24) model_apply(w);
    repeat (12) @(negedge clk);
    settled = 1'b1;
    chk(ser_sdo === 1'b1, "R5 sdo idle", 32'(ser_sdo), 32'h1);
  endtask

  task automatic expect_w(input logic [9:0] e0, input logic [9:0] e1, input string req);
    chk(wiper_pos === {e1, e0}, req, 32'(wiper_pos), 32'({e1, e0}));
  endtask

  task automatic pulse_preset();
    settled = 1'b0;
    preset_n = 1'b0;
    repeat (5) @(negedge clk);
    preset_n = 1'b1;
    mw[0] = NV0;
    mw[1] = NV1;
    repeat (10) @(negedge clk);
    settled = 1'b1;
  endtask

  // reference comparison on every settled clock
  always @(negedge clk) begin
    if (!rst && settled)
      chk(wiper_pos === {mw[1], mw[0]}, "R9 wiper model", 32'(wiper_pos), 32'({mw[1], mw[0]}));
  end

  always @(negedge clk) begin
    if (!rst && store_req) begin
      st_seen++;
      st_addr = store_addr;
      st_data = store_data;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int s0;
    mw[0] = 10'd512;
    mw[1] = 10'd512;
    load_q(24'h0);
    repeat (4) @(negedge clk);
    // R1: state held in reset
    expect_w(10'd512, 10'd512, "R1 reset wipers");
    chk(ser_sdo === 1'b1, "R1 reset sdo", 32'(ser_sdo), 32'h1);
    chk(store_req === 1'b0, "R1 reset store_req", 32'(store_req), 32'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    expect_w(10'd512, 10'd512, "R1 after reset");
    settled = 1'b1;

    // R2 writes
    send(fr(11, 0, 16'h0155), 24);
    expect_w(10'h155, 10'd512, "R2 write ch0");
    send(fr(11, 1, 16'hF3FF), 24);
    expect_w(10'h155, 10'h3FF, "R2 write ch1 low bits");

    // R12 nop and unassigned code; R6 echo checked during these frames
    s0 = st_seen;
    send(fr(0, 0, 16'h0000), 24);
    send(fr(5, 0, 16'h0077), 24);
    expect_w(10'h155, 10'h3FF, "R12 nop/unassigned");
    chk(st_seen == s0, "R12 no store", 32'(st_seen), 32'(s0));

    // R3 bad lengths
    send(fr(11, 0, 16'h00F0), 23);
    expect_w(10'h155, 10'h3FF, "R3 short frame");
    send(fr(11, 0, 16'h00F0), 25);
    expect_w(10'h155, 10'h3FF, "R3 long frame");
    send(fr(2, 1, 16'h0000), 23);
    chk(st_seen == s0, "R3 short store ignored", 32'(st_seen), 32'(s0));

    // R4 invalid address
    send(fr(11, 7, 16'h0001), 24);
    expect_w(10'h155, 10'h3FF, "R4 invalid address");

    // R7 readback, checked bit by bit in the following frame
    send(fr(10, 1, 16'h0000), 24);
    send(fr(0, 0, 16'h0000), 24);
    send(fr(9, 0, 16'h0000), 24);
    send(fr(0, 0, 16'h0000), 24);
    send(fr(10, 9, 16'h0000), 24);
    send(fr(0, 0, 16'h0000), 24);

    // R11 store
    send(fr(2, 1, 16'h0000), 24);
    chk(st_seen == s0 + 1, "R11 store count", 32'(st_seen), 32'(s0 + 1));
    chk(st_addr == 4'd1, "R11 store addr", 32'(st_addr), 32'h1);
    chk(st_data == 10'h3FF, "R11 store data", 32'(st_data), 32'h3FF);
    send(fr(2, 3, 16'h0000), 24);
    chk(st_seen == s0 + 1, "R11 invalid addr store", 32'(st_seen), 32'(s0 + 1));

    // R9 reloads
    send(fr(1, 0, 16'h0000), 24);
    expect_w(NV0, 10'h3FF, "R9 reload ch0");
    send(fr(11, 1, 16'h0100), 24);
    send(fr(11, 0, 16'h0050), 24);
    send(fr(8, 0, 16'h0000), 24);
    expect_w(NV0, NV1, "R9 reload all");

    // R8 write protect
    send(fr(11, 0, 16'h0050), 24);
    send(fr(11, 1, 16'h0060), 24);
    wp_n = 1'b0;
    repeat (10) @(negedge clk);
    send(fr(11, 0, 16'h0222), 24);
    send(fr(1, 1, 16'h0000), 24);
    send(fr(8, 0, 16'h0000), 24);
    expect_w(10'h050, 10'h060, "R8 protect blocks");

    // R10 preset under protect
    pulse_preset();
    expect_w(NV0, NV1, "R10 preset reload");
    wp_n = 1'b1;
    repeat (10) @(negedge clk);
    send(fr(11, 1, 16'h0123), 24);
    expect_w(NV0, 10'h123, "R8 protect released");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule